// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the register face of a legacy keyboard controller. It sits between a narrow host I/O bus and a source of keyboard scancodes. The host sees two byte-wide ports, chosen by a single select line. The command/status port returns a status byte when read and takes controller commands when written. The data port hands over the buffered scancode when read and takes a parameter byte when written.

The keyboard side delivers one byte at a time with a valid strobe. The block holds one scancode until the host reads it, and it drives a small LED bus. Host software writes a command, polls the ready bit of the status byte, and then reads the data port. A data-port write is treated as an LED value only when the set-LEDs command came just before it. Otherwise the write changes nothing.

Top module: `kbd_port_regs`

## Requirements
- R1: After reset, the status byte reads 0x00, the LED output is 0 and the keyboard interface is disabled.
- R2: With host_sel=1, host_rdata is the status byte: bit 0 output-buffer-full, bit 1 input-busy, bit 2 system flag; bits 7:3 always read 0. With host_sel=0, host_rdata is the output buffer.
- R3: Input-busy (status bit 1) is 1 in the cycle after any host write, to either port, and returns to 0 in the following cycle when no further write occurs.
- R4: Command 0xAA (self test) loads 0x55 into the output buffer, sets output-buffer-full and sets the system flag (status bit 2), all visible in the cycle after the write.
- R5: Scancodes are not captured until command 0xAE has been written. Before that, key_valid leaves output-buffer-full at 0.
- R6: Once the interface is enabled, a key_valid pulse arrives while output-buffer-full is 0. The code is captured, bit 0 becomes 1 in the next cycle, and a data-port read returns the code.
- R7: A data-port read (host_rd with host_sel=0) while output-buffer-full is 1 clears that bit in the next cycle.
- R8: A scancode that arrives while output-buffer-full is 1 is dropped, and the buffered byte is kept.
- R9: After command 0xED, the next data-port write sets the LED output to bits 2:0 of the written byte.
- R10: A data-port write with no set-LEDs command pending, and any command other than 0xAA, 0xAE or 0xED, leaves the LED output and output-buffer-full unchanged.
- R11: When a self-test write and a key_valid pulse land in the same cycle, the self-test reply 0x55 is the byte that gets buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 1 = command/status port, 0 = data port |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (status or buffered byte) |
| key_code | input | 8 | Scancode from the keyboard side |
| key_valid | input | 1 | Scancode strobe, one cycle per byte |
| led_out | output | LED_W | LED state driven to the keyboard |

## Verification
Each internal error shows up at the ports within one or two cycles. A lost enable or a stuck full bit shows up as a missing or unexpected bit 0 in the very next status read. A buffer overwritten by a late scancode, or a wrong self-test reply, shows up as a wrong byte on the next data-port read. A pending set-LEDs flag that is never cleared would let a second data write move the LEDs. So each LED value is followed by a stray data write, and the LED output is checked again afterwards.

// File: rtl/kbd_port_regs.sv
module kbd_port_regs #(
  parameter int LED_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic [7:0]       key_code,
  input  logic             key_valid,
  output logic [LED_W-1:0] led_out
);
  localparam logic [7:0] CMD_TEST  = 8'hAA;
  localparam logic [7:0] CMD_KBON  = 8'hAE;
  localparam logic [7:0] CMD_LEDS  = 8'hED;
  localparam logic [7:0] TEST_OK   = 8'h55;

  logic [7:0]       obuf;
  logic             obs, ibs, sysf, kb_en, led_pend;
  logic [LED_W-1:0] led_q;

  wire cmd_wr   = host_wr & host_sel;
  wire data_wr  = host_wr & ~host_sel;
  wire data_rd  = host_rd & ~host_sel;
  wire do_test  = cmd_wr & (host_wdata == CMD_TEST);
  wire take_key = key_valid & kb_en & ~obs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obuf     <= '0;
      obs      <= 1'b0;
      ibs      <= 1'b0;
      sysf     <= 1'b0;
      kb_en    <= 1'b0;
      led_pend <= 1'b0;
      led_q    <= '0;
    end else begin
      ibs <= host_wr;
      if (do_test) begin
        obuf <= TEST_OK;
        obs  <= 1'b1;
        sysf <= 1'b1;
      end else if (take_key) begin
        obuf <= key_code;
        obs  <= 1'b1;
      end else if (data_rd) begin
        obs  <= 1'b0;
      end
      if (cmd_wr && host_wdata == CMD_KBON) kb_en <= 1'b1;
      if (cmd_wr) led_pend <= (host_wdata == CMD_LEDS);
      else if (data_wr && led_pend) begin
        led_q    <= host_wdata[LED_W-1:0];
        led_pend <= 1'b0;
      end
    end
  end

  assign host_rdata = host_sel ? {5'b0, sysf, ibs, obs} : obuf;
  assign led_out    = led_q;
endmodule

module kbd_port_regs_chk #(
  parameter int LED_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_sel,
  input logic             host_wr,
  input logic             host_rd,
  input logic [7:0]       host_wdata,
  input logic [7:0]       obuf,
  input logic             obs,
  input logic             ibs,
  input logic             kb_en,
  input logic             key_valid,
  input logic [LED_W-1:0] led_out
);
  wire test_w = host_wr & host_sel & (host_wdata == 8'hAA);

  AST_IBS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> ibs); // R3
  AST_IBS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> !ibs); // R3
  AST_SELF_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    test_w |=> (obs && obuf == 8'h55)); // R4
  AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !kb_en && !obs && !test_w) |=> !obs); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_sel && obs && !test_w) |=> !obs); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (obs && !test_w) |=> $stable(obuf)); // R8
  AST_LED_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && !host_sel) |=> $stable(led_out)); // R10
endmodule

bind kbd_port_regs kbd_port_regs_chk #(.LED_W(LED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .obuf(obuf), .obs(obs),
  .ibs(ibs), .kb_en(kb_en), .key_valid(key_valid), .led_out(led_out)
);

// File: tb/sim_kbd_port_regs.sv
module sim_kbd_port_regs;
  logic clk = 0, rst_n = 0;
  logic host_sel = 0, host_wr = 0, host_rd = 0, key_valid = 0;
  logic [7:0] host_wdata = 0, key_code = 0;
  logic [7:0] host_rdata;
  logic [2:0] led_out;
  int checks = 0, errors = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  kbd_port_regs u0 (.clk, .rst_n, .host_sel, .host_wr, .host_rd,
    .host_wdata, .host_rdata, .key_code, .key_valid, .led_out);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic hwrite(input logic sel, input logic [7:0] d);
    host_sel = sel; host_wr = 1; host_wdata = d; tick(); host_wr = 0;
  endtask

  task automatic status(output logic [7:0] s);
    host_sel = 1; #1; s = host_rdata;
  endtask

  task automatic hread(output logic [7:0] d);
    host_sel = 0; host_rd = 1; #1; d = host_rdata; tick(); host_rd = 0;
  endtask

  task automatic key(input logic [7:0] c);
    key_valid = 1; key_code = c; tick(); key_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    status(rd); check("R1 status", rd, 8'h00);
    check("R1 led", led_out, 0);
    key(8'h3C); tick(); status(rd); check("R5 disabled drop", rd, 8'h00);
    hwrite(0, 8'h07); tick(); check("R10 stray data write", led_out, 0);
    hwrite(1, 8'h12); tick(); status(rd); check("R10 unknown cmd", rd, 8'h00);
    check("R10 unknown cmd led", led_out, 0);
    hwrite(1, 8'hAA); status(rd); check("R4 R2 R3 after test", rd, 8'h07);
    tick(); status(rd); check("R3 busy clears", rd, 8'h05);
    hread(rd); check("R4 reply", rd, 8'h55);
    status(rd); check("R7 read clears", rd, 8'h04);
    hwrite(1, 8'hAE); tick();
    for (int c = 0; c < 256; c++) begin
      key(c[7:0]); status(rd); check("R6 captured", rd, 8'h05);
      key(~c[7:0]); hread(rd); check("R8 R6 kept first", rd, c);
      status(rd); check("R7 cleared", rd, 8'h04);
    end
    for (int v = 0; v < 256; v++) begin
      hwrite(1, 8'hED); hwrite(0, v[7:0]);
      check("R9 led set", led_out, v % 8);
      hwrite(0, ~v[7:0]); check("R10 led held", led_out, v % 8);
    end
    host_sel = 1; host_wr = 1; host_wdata = 8'hAA; key_valid = 1; key_code = 8'h99;
    tick(); host_wr = 0; key_valid = 0;
    hread(rd); check("R11 test wins", rd, 8'h55);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule